// File: doc/BRIEF.md
# Interrupt Pin Delivery and End-of-Interrupt Engine

This block turns interrupt pin activity into delivery messages for a set of receiving processors. Each pin has a routing entry that holds the vector, destination, destination mode, delivery mode, polarity, trigger mode and mask. A source reports a pin's level by pulsing that pin's update strobe together with the level. The engine keeps a request bit for every pin. For level-triggered pins it also keeps a remote-pending bit. From these bits it decides whether the report starts a delivery, is absorbed as coalesced, or is simply recorded. Deliveries leave through a single valid/ready message port.

End-of-interrupt notices arrive as a vector plus a level/edge flag. Every entry whose vector matches gets a one-cycle acknowledge pulse. A level notice also clears the entry's remote-pending bit and, when the line is still requesting and the entry is unmasked, schedules a fresh delivery. Routing entries are written one whole entry at a time through a simple write strobe. A write also re-evaluates a level-triggered pin that is still requesting.

Top module: `irq_route_engine`

## Requirements
- R1: After reset every routing entry is masked (all other fields zero), every request, remote-pending and scheduled bit is clear, `msgValid` is low, and no coalesced or acknowledge pulse is raised.
- R2: A pin's effective level is `pinLvl` XOR the entry's polarity bit (entry bit 20). All further rules use the effective level.
- R3: On an edge-triggered pin (entry bit 21 = 0), an update with effective level 1 schedules a delivery only when the request bit was 0. If the request bit was already 1, the pin's `coalescePulse` bit is high for exactly the cycle after the update edge and no message is produced.
- R4: An update with effective level 0 clears the pin's request bit and produces neither a message nor a coalesced pulse.
- R5: On a level-triggered pin (entry bit 21 = 1), an update with effective level 1 schedules a delivery when remote-pending is 0 and sets remote-pending in the same cycle. With remote-pending already 1, the update only raises the coalesced pulse.
- R6: An entry with its mask bit (entry bit 22) set never produces a message. A write that sets the mask withdraws a delivery that is scheduled but not yet presented.
- R7: A level end-of-interrupt (`eoiLevel` = 1) clears remote-pending on every entry whose vector matches `eoiVector`. It schedules a new delivery for each such entry that is unmasked and whose request bit is still 1.
- R8: An edge end-of-interrupt (`eoiLevel` = 0) leaves remote-pending unchanged and schedules nothing.
- R9: For each entry whose vector matches a valid end-of-interrupt, its `eoiAck` bit is high for the single cycle after the notice edge. This holds whatever the trigger mode or mask. Without a notice, no acknowledge bit rises.
- R10: A message carries the entry's vector (bits 7:0), destination (bits 15:8), delivery mode (bits 18:16), destination mode (bit 19) and trigger mode (bit 21), with `msgLevel` = 1 and the pin number on `msgPin`. It becomes valid after the second rising edge that follows the triggering input.
- R11: When several pins are scheduled, the lowest-numbered pin is presented first. A presented message keeps all its fields stable while `msgReady` is low. Scheduled pins wait, and none are lost.
- R12: Writing a routing entry clears that pin's remote-pending bit. If the new entry is level-triggered, unmasked and the pin's request bit is 1, a delivery is scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tblWe | input | 1 | Routing entry write strobe |
| tblIdx | input | PIN_IDX_W | Entry index for the write |
| tblData | input | ENT_W | Whole routing entry to write |
| pinUpd | input | NUM_PINS | Per-pin level report strobe |
| pinLvl | input | NUM_PINS | Raw level reported with the strobe |
| eoiValid | input | 1 | End-of-interrupt notice strobe |
| eoiVector | input | VEC_W | Vector of the notice |
| eoiLevel | input | 1 | 1 = level notice, 0 = edge notice |
| msgValid | output | 1 | Delivery message present |
| msgReady | input | 1 | Receiver accepts the message |
| msgPin | output | PIN_IDX_W | Source pin of the message |
| msgDest | output | DEST_W | Destination |
| msgVector | output | VEC_W | Vector |
| msgDestMode | output | 1 | Destination mode |
| msgTrigMode | output | 1 | Trigger mode, 1 = level |
| msgDelMode | output | DMODE_W | Delivery mode |
| msgLevel | output | 1 | Level bit of the message, always asserted |
| coalescePulse | output | NUM_PINS | Per-pin coalesced report pulse |
| eoiAck | output | NUM_PINS | Per-pin end-of-interrupt match pulse |

## Verification
Coalesced and acknowledge pulses are registered, so they are due in the cycle after the edge that samples the stimulus. The bench reads them at the falling edge that follows that one edge. A message needs a second edge to move from the scheduled bits into the output register. One check therefore reads `msgValid` low after the first edge and high after the second, and another watches it hold while `msgReady` is low. Expected messages are queued at the time of stimulus and matched in order at each accepted handshake, sampled on falling edges. Any message that arrives while the queue is empty counts as a failure, which is how withheld deliveries are caught.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int VEC_W     = 8;
  parameter int DEST_W    = 8;
  parameter int DMODE_W   = 3;
  parameter int PIN_IDX_W = 5;

  // Routing entry; bit positions are observed by software-visible writes.
  typedef struct packed {
    logic               mask;
    logic               trigLevel;
    logic               polarity;
    logic               destMode;
    logic [DMODE_W-1:0] delMode;
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vector;
  } route_ent_t;

  localparam int ENT_W = $bits(route_ent_t);
  localparam route_ent_t ENT_RESET = '{mask: 1'b1, default: '0};

  // Fields an entry contributes to a delivery message.
  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vector;
    logic               destMode;
    logic               trigLevel;
    logic [DMODE_W-1:0] delMode;
  } deliv_t;

  typedef struct packed {
    logic [PIN_IDX_W-1:0] pin;
    deliv_t               body;
  } msg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 load;
    logic [PIN_IDX_W-1:0] pin;
  } ctl_strb_t;
endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrHit,
  input  route_ent_t       wrEnt,
  input  logic             updHit,
  input  logic             rawLvl,
  input  logic             eoiValid,
  input  logic [VEC_W-1:0] eoiVector,
  input  logic             eoiLevel,
  input  logic             loadHit,
  output deliv_t           fields,
  output logic             pend,
  output logic             coalPulse,
  output logic             ackPulse
);
  route_ent_t ent, entNext;
  logic req, remote;
  logic eoiHit, eoiLvlHit, eff, reqNext, remMid;
  logic edgeRise, lvlFire, redo, svc, coal;

  always_comb begin
    entNext   = wrHit ? wrEnt : ent;
    eoiHit    = eoiValid && (entNext.vector == eoiVector);
    eoiLvlHit = eoiHit && eoiLevel;
    // write and level notice both release the remote-pending gate
    remMid    = remote && !wrHit && !eoiLvlHit;
    eff       = rawLvl ^ entNext.polarity;
    reqNext   = updHit ? eff : req;
    edgeRise  = updHit && eff && !entNext.trigLevel && !req;
    lvlFire   = updHit && eff && entNext.trigLevel && !remMid;
    coal      = updHit && eff && (entNext.trigLevel ? remMid : req);
    redo      = reqNext && ((wrHit && entNext.trigLevel) || eoiLvlHit);
    svc       = (edgeRise || lvlFire || redo) && !entNext.mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent       <= ENT_RESET;
      req       <= 1'b0;
      remote    <= 1'b0;
      pend      <= 1'b0;
      coalPulse <= 1'b0;
      ackPulse  <= 1'b0;
    end else begin
      ent       <= entNext;
      req       <= reqNext;
      remote    <= remMid || (svc && entNext.trigLevel);
      pend      <= (pend && !loadHit && !(wrHit && wrEnt.mask)) || svc;
      coalPulse <= coal;
      ackPulse  <= eoiHit;
    end
  end

  always_comb begin
    fields.dest      = ent.dest;
    fields.vector    = ent.vector;
    fields.destMode  = ent.destMode;
    fields.trigLevel = ent.trigLevel;
    fields.delMode   = ent.delMode;
  end
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tblWe,
  input  logic [PIN_IDX_W-1:0] tblIdx,
  input  route_ent_t           tblData,
  input  logic [NUM_PINS-1:0]  pinUpd,
  input  logic [NUM_PINS-1:0]  pinLvl,
  input  logic                 eoiValid,
  input  logic [VEC_W-1:0]     eoiVector,
  input  logic                 eoiLevel,
  input  ctl_strb_t            strb,
  output logic [NUM_PINS-1:0]  pendVec,
  output msg_t                 msgQ,
  output logic [NUM_PINS-1:0]  coalVec,
  output logic [NUM_PINS-1:0]  ackVec
);
  deliv_t fieldArr [NUM_PINS];
  deliv_t selBody;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : gPin
      irq_pin_slice uSlice (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrHit     (tblWe && (tblIdx == PIN_IDX_W'(g))),
        .wrEnt     (tblData),
        .updHit    (pinUpd[g]),
        .rawLvl    (pinLvl[g]),
        .eoiValid  (eoiValid),
        .eoiVector (eoiVector),
        .eoiLevel  (eoiLevel),
        .loadHit   (strb.load && (strb.pin == PIN_IDX_W'(g))),
        .fields    (fieldArr[g]),
        .pend      (pendVec[g]),
        .coalPulse (coalVec[g]),
        .ackPulse  (ackVec[g])
      );
    end
  endgenerate

  always_comb begin
    selBody = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (strb.pin == PIN_IDX_W'(i)) selBody = fieldArr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msgQ <= '0;
    end else if (strb.load) begin
      msgQ.pin  <= strb.pin;
      msgQ.body <= selBody;
    end
  end
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pendVec,
  input  logic                msgReady,
  output ctl_strb_t           strb,
  output logic                msgValid
);
  logic [PIN_IDX_W-1:0] selPin;
  logic canLoad;

  // lowest-numbered scheduled pin wins
  always_comb begin
    selPin = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pendVec[i]) selPin = PIN_IDX_W'(i);
    end
  end

  always_comb begin
    canLoad   = !msgValid || msgReady;
    strb.load = canLoad && (|pendVec);
    strb.pin  = selPin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              msgValid <= 1'b0;
    else if (strb.load)      msgValid <= 1'b1;
    else if (msgReady)       msgValid <= 1'b0;
  end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tblWe,
  input  logic [PIN_IDX_W-1:0] tblIdx,
  input  logic [ENT_W-1:0]     tblData,
  input  logic [NUM_PINS-1:0]  pinUpd,
  input  logic [NUM_PINS-1:0]  pinLvl,
  input  logic                 eoiValid,
  input  logic [VEC_W-1:0]     eoiVector,
  input  logic                 eoiLevel,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [PIN_IDX_W-1:0] msgPin,
  output logic [DEST_W-1:0]    msgDest,
  output logic [VEC_W-1:0]     msgVector,
  output logic                 msgDestMode,
  output logic                 msgTrigMode,
  output logic [DMODE_W-1:0]   msgDelMode,
  output logic                 msgLevel,
  output logic [NUM_PINS-1:0]  coalescePulse,
  output logic [NUM_PINS-1:0]  eoiAck
);
  ctl_strb_t strb;
  msg_t msgQ;
  logic [NUM_PINS-1:0] pendVec;

  irq_route_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tblWe     (tblWe),
    .tblIdx    (tblIdx),
    .tblData   (route_ent_t'(tblData)),
    .pinUpd    (pinUpd),
    .pinLvl    (pinLvl),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .eoiLevel  (eoiLevel),
    .strb      (strb),
    .pendVec   (pendVec),
    .msgQ      (msgQ),
    .coalVec   (coalescePulse),
    .ackVec    (eoiAck)
  );

  irq_route_ctl #(.NUM_PINS(NUM_PINS)) uCtl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pendVec  (pendVec),
    .msgReady (msgReady),
    .strb     (strb),
    .msgValid (msgValid)
  );

  assign msgPin      = msgQ.pin;
  assign msgDest     = msgQ.body.dest;
  assign msgVector   = msgQ.body.vector;
  assign msgDestMode = msgQ.body.destMode;
  assign msgTrigMode = msgQ.body.trigLevel;
  assign msgDelMode  = msgQ.body.delMode;
  assign msgLevel    = 1'b1;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PINS-1:0]  pinUpd,
  input logic                 eoiValid,
  input logic [NUM_PINS-1:0]  eoiAck,
  input logic [NUM_PINS-1:0]  coalescePulse,
  input logic                 msgValid,
  input logic                 msgReady,
  input logic [PIN_IDX_W-1:0] msgPin,
  input logic [VEC_W-1:0]     msgVector,
  input logic [DEST_W-1:0]    msgDest,
  input logic [NUM_PINS-1:0]  pendVec
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid && !msgReady |=> msgValid && $stable(msgPin) && $stable(msgVector) && $stable(msgDest));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pendVec != '0) |=> msgValid);

  assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid && msgReady && (pendVec == '0) |=> !msgValid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !msgValid && (pendVec == '0) |=> !msgValid);

  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eoiValid |=> (eoiAck == '0));

  assert_coal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pinUpd == '0) |=> (coalescePulse == '0));
endmodule

bind irq_route_engine irq_route_chk #(.NUM_PINS(NUM_PINS)) uChk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pinUpd        (pinUpd),
  .eoiValid      (eoiValid),
  .eoiAck        (eoiAck),
  .coalescePulse (coalescePulse),
  .msgValid      (msgValid),
  .msgReady      (msgReady),
  .msgPin        (msgPin),
  .msgVector     (msgVector),
  .msgDest       (msgDest),
  .pendVec       (pendVec)
);

// File: tb/sim_irq_route_engine.sv
`timescale 1ns/1ps
module sim_irq_route_engine;
  localparam int NP = 8;

  typedef struct packed {
    logic [4:0] pin;
    logic [7:0] dest;
    logic [7:0] vec;
    logic       dm;
    logic       trig;
    logic [2:0] del;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tblWe = 1'b0;
  logic [4:0] tblIdx = '0;
  logic [22:0] tblData = '0;
  logic [NP-1:0] pinUpd = '0;
  logic [NP-1:0] pinLvl = '0;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = '0;
  logic eoiLevel = 1'b0;
  logic msgReady = 1'b1;
  logic msgValid, msgDestMode, msgTrigMode, msgLevel;
  logic [4:0] msgPin;
  logic [7:0] msgDest, msgVector;
  logic [2:0] msgDelMode;
  logic [NP-1:0] coalescePulse, eoiAck;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t expQ[$];
  string tagQ[$];
  logic [22:0] mirror [NP];

  always #4 clk = ~clk;

  irq_route_engine #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .tblWe(tblWe), .tblIdx(tblIdx), .tblData(tblData),
    .pinUpd(pinUpd), .pinLvl(pinLvl), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .eoiLevel(eoiLevel), .msgValid(msgValid), .msgReady(msgReady), .msgPin(msgPin),
    .msgDest(msgDest), .msgVector(msgVector), .msgDestMode(msgDestMode),
    .msgTrigMode(msgTrigMode), .msgDelMode(msgDelMode), .msgLevel(msgLevel),
    .coalescePulse(coalescePulse), .eoiAck(eoiAck)
  );

  function automatic logic [22:0] mkEnt(logic [7:0] vec, logic [7:0] dest, logic [2:0] del,
                                        logic dm, logic pol, logic lvl, logic msk);
    return {msk, lvl, pol, dm, del, dest, vec};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_msg(input int pin, input string tag);
    exp_t e;
    e.pin  = 5'(pin);
    e.vec  = mirror[pin][7:0];
    e.dest = mirror[pin][15:8];
    e.del  = mirror[pin][18:16];
    e.dm   = mirror[pin][19];
    e.trig = mirror[pin][21];
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor: compares each accepted message
  always @(negedge clk) begin
    if (rst_n && msgValid && msgReady) begin
      exp_t got;
      got = '{pin: msgPin, dest: msgDest, vec: msgVector, dm: msgDestMode,
              trig: msgTrigMode, del: msgDelMode};
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected message", 64'(got), 64'(0));
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(got == e && msgLevel, t, 64'({msgLevel, got}), 64'({1'b1, e}));
      end
    end
  end

  task automatic wrEnt(input int idx, input logic [22:0] ent);
    mirror[idx] = ent;
    @(posedge clk); #1;
    tblWe = 1'b1; tblIdx = 5'(idx); tblData = ent;
    @(posedge clk); #1;
    tblWe = 1'b0;
  endtask

  task automatic pinEvt(input logic [NP-1:0] upd, input logic [NP-1:0] lvl,
                        input logic [NP-1:0] expCoal, input string tag);
    @(posedge clk); #1;
    pinUpd = upd; pinLvl = lvl;
    @(posedge clk); #1;
    pinUpd = '0;
    @(negedge clk);
    chk(coalescePulse == expCoal, tag, 64'(coalescePulse), 64'(expCoal));
  endtask

  task automatic eoi(input logic [7:0] vec, input logic lvl, input logic [NP-1:0] expAck,
                     input string tag);
    @(posedge clk); #1;
    eoiValid = 1'b1; eoiVector = vec; eoiLevel = lvl;
    @(posedge clk); #1;
    eoiValid = 1'b0;
    @(negedge clk);
    chk(eoiAck == expAck, tag, 64'(eoiAck), 64'(expAck));
  endtask

  task automatic setReady(input logic r);
    @(posedge clk); #1;
    msgReady = r;
  endtask

  task automatic drained(input string tag);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, tag, 64'(expQ.size()), 64'(0));
  endtask

  initial begin
    for (int i = 0; i < NP; i++) mirror[i] = 23'h400000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!msgValid, "R1 msgValid", 64'(msgValid), 64'(0));
    chk(coalescePulse == '0 && eoiAck == '0, "R1 pulses", 64'({coalescePulse, eoiAck}), 64'(0));
    pinEvt(8'h01, 8'h01, 8'h00, "R1 masked after reset");
    pinEvt(8'h01, 8'h00, 8'h00, "R4 low clears");
    drained("R1 no delivery");

    // R3 / R4: edge pin 2
    wrEnt(2, mkEnt(8'h32, 8'h05, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    expect_msg(2, "R3 edge delivery");
    pinEvt(8'h04, 8'h04, 8'h00, "R3 first rise");
    pinEvt(8'h04, 8'h04, 8'h04, "R3 coalesced");
    pinEvt(8'h04, 8'h00, 8'h00, "R4 drop");
    expect_msg(2, "R4 re-rise delivery");
    pinEvt(8'h04, 8'h04, 8'h00, "R3 second rise");
    drained("R3 drained");

    // R2: inverted polarity, pin 4
    wrEnt(4, mkEnt(8'h44, 8'h09, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0));
    pinEvt(8'h10, 8'h10, 8'h00, "R2 raw high is inactive");
    expect_msg(4, "R2 raw low delivers");
    pinEvt(8'h10, 8'h00, 8'h00, "R2 raw low");
    pinEvt(8'h10, 8'h00, 8'h10, "R2 coalesced");
    drained("R2 drained");

    // R5 / R7 / R8: level pin 5
    wrEnt(5, mkEnt(8'h55, 8'h21, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0));
    expect_msg(5, "R5 level delivery");
    pinEvt(8'h20, 8'h20, 8'h00, "R5 assert");
    pinEvt(8'h20, 8'h20, 8'h20, "R5 gated by remote");
    eoi(8'h55, 1'b0, 8'h20, "R9 ack edge notice");
    pinEvt(8'h20, 8'h20, 8'h20, "R8 remote kept");
    expect_msg(5, "R7 redelivery");
    eoi(8'h55, 1'b1, 8'h20, "R7 ack level notice");
    drained("R7 redelivered");
    pinEvt(8'h20, 8'h00, 8'h00, "R4 level drop");
    eoi(8'h55, 1'b1, 8'h20, "R7 ack no request");
    drained("R7 no redelivery when idle");
    expect_msg(5, "R5 after clear");
    pinEvt(8'h20, 8'h20, 8'h00, "R5 re-assert");
    drained("R5 drained");

    // R9: shared vector across pins 5, 6 (edge), 7 (masked)
    wrEnt(6, mkEnt(8'h55, 8'h01, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    wrEnt(7, mkEnt(8'h55, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    eoi(8'h55, 1'b0, 8'he0, "R9 shared edge notice");
    expect_msg(5, "R9 level notice redelivers pin 5");
    eoi(8'h55, 1'b1, 8'he0, "R9 shared level notice");
    drained("R9 drained");

    // R6: masking
    wrEnt(3, mkEnt(8'h33, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    pinEvt(8'h08, 8'h08, 8'h00, "R6 masked rise");
    setReady(1'b0);
    wrEnt(1, mkEnt(8'h11, 8'h03, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    expect_msg(1, "R6 occupying message");
    pinEvt(8'h02, 8'h02, 8'h00, "R6 pin 1 rise");
    wrEnt(0, mkEnt(8'h10, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pinEvt(8'h01, 8'h01, 8'h00, "R6 pin 0 rise");
    wrEnt(0, mkEnt(8'h10, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    setReady(1'b1);
    drained("R6 withdrawn");

    // R10 / R11: latency, priority, hold
    pinEvt(8'h14, 8'h10, 8'h00, "R4 lower pins 2 and 4");
    setReady(1'b0);
    pinEvt(8'h14, 8'h04, 8'h00, "R11 joint rise");
    chk(!msgValid, "R10 not valid after first edge", 64'(msgValid), 64'(0));
    @(negedge clk);
    chk(msgValid && msgPin == 5'd2, "R11 lowest first", 64'({msgValid, msgPin}), 64'({1'b1, 5'd2}));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(msgValid && msgPin == 5'd2 && msgVector == 8'h32, "R11 held",
          64'({msgValid, msgPin, msgVector}), 64'({1'b1, 5'd2, 8'h32}));
    end
    expect_msg(2, "R11 first");
    expect_msg(4, "R11 second");
    setReady(1'b1);
    drained("R11 drained");

    // R12: table write re-services level pin 5 (remote set, request set)
    wrEnt(5, mkEnt(8'h56, 8'h21, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0));
    expect_msg(5, "R12 write redelivery");
    drained("R12 write redelivery");
    pinEvt(8'h20, 8'h20, 8'h20, "R12 remote set again");
    wrEnt(6, mkEnt(8'h66, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    drained("R12 no request no delivery");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule